// File: doc/BRIEF.md
# Halt wake-up and reset-cause controller

This block sits beside a small CPU core and governs its low-power halt state. When the core executes its halt command, the controller stalls the core, restarts the watchdog and records in two status flags that a power-down took place. Software reads these flags later to tell a cold start, a halt wake-up and a watchdog time-out apart.

While halted, the controller watches three wake sources: falling edges on an 8-bit input port (each bit enabled on its own), interrupt request flags that rise after halt entry, and watchdog overflow. An external reset is the fourth way out and re-initialises everything. Every wake-up is followed by a fixed settling delay. At the end of it the controller emits one single-cycle pulse. The pulse tells the core to continue at the next instruction, to take the interrupt, or to perform a warm reset of its program counter and stack pointer.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `pd_flag`, `to_flag`, `cpu_hold`, `resume_next`, `int_entry` and `warm_rst` are all 0.
- R2: When `halt_cmd` is high in the running state without `wdt_ovf`, `wdt_clear` is high in that same cycle. From the next cycle, `cpu_hold`=1, `pd_flag`=1 and `to_flag`=0.
- R3: A `clrwdt_cmd` pulse without `halt_cmd` makes `pd_flag` 0 in the next cycle and leaves `to_flag` unchanged.
- R4: `wdt_ovf` sets `to_flag` in the next cycle. In the running state it raises `warm_rst` in the next cycle. In halt it wakes the device and ends in `warm_rst`, and it takes precedence over any port or interrupt wake seen in the same cycle.
- R5: During halt, a 1-to-0 change on `port_in[i]` wakes the device only when `port_wake_en[i]`=1. Rising edges and edges on disabled bits leave `cpu_hold` at 1. A port wake-up ends in `resume_next`.
- R6: An interrupt flag that is already 1 when halt is entered cannot wake the device. A flag that changes from 0 to 1 during halt does wake it.
- R7: An interrupt wake-up ends in `int_entry` when at least one newly raised flag has its `irq_en` bit set and `stack_full`=0. Otherwise it ends in `resume_next`.
- R8: The exit pulse appears exactly `WAKE_DELAY` (1024) clock cycles after the clock edge at which the wake event is registered. `cpu_hold` stays 1 until then.
- R9: At most one of `resume_next`, `int_entry` and `warm_rst` is high at a time. Each lasts one cycle, and `cpu_hold` is 0 from the exit cycle on.
- R10: Driving `rst_n` low during halt returns every flag and output to the state given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| halt_cmd | input | 1 | Core executes the halt command |
| clrwdt_cmd | input | 1 | Core executes the clear-watchdog command |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| port_in | input | 8 | Input port pins watched for wake-up |
| port_wake_en | input | 8 | Per-bit falling-edge wake enable |
| irq_flags | input | 4 | Interrupt request flags |
| irq_en | input | 4 | Per-interrupt enables |
| stack_full | input | 1 | Core's return stack has no free entry |
| cpu_hold | output | 1 | Stall the core (halt and settling delay) |
| wdt_clear | output | 1 | Restart the watchdog count |
| pd_flag | output | 1 | Power-down status flag |
| to_flag | output | 1 | Watchdog time-out status flag |
| resume_next | output | 1 | Continue at the next instruction |
| int_entry | output | 1 | Take the interrupt response |
| warm_rst | output | 1 | Reinitialise PC and SP only |

## Verification
Two pairs of wake causes can land in the same cycle. The bench raises a watchdog overflow together with an enabled port falling edge during halt. It expects `warm_rst` rather than `resume_next`, and `to_flag` set. It also raises a new interrupt flag while a stale one is still pending. It expects the wake and its choice between resume and interrupt entry to follow only the new flag, with exact delay counting from the wake edge.

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl #(
  parameter int PORT_W     = 8,
  parameter int IRQ_N      = 4,
  parameter int WAKE_DELAY = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_cmd,
  input  logic              clrwdt_cmd,
  input  logic              wdt_ovf,
  input  logic [PORT_W-1:0] port_in,
  input  logic [PORT_W-1:0] port_wake_en,
  input  logic [IRQ_N-1:0]  irq_flags,
  input  logic [IRQ_N-1:0]  irq_en,
  input  logic              stack_full,
  output logic              cpu_hold,
  output logic              wdt_clear,
  output logic              pd_flag,
  output logic              to_flag,
  output logic              resume_next,
  output logic              int_entry,
  output logic              warm_rst
);

  localparam int CW = $clog2(WAKE_DELAY + 1);
  localparam logic [CW-1:0] LAST = CW'(WAKE_DELAY - 1);

  typedef enum logic [1:0] {S_RUN, S_HALT, S_WAKE, S_EXIT} state_t;
  typedef enum logic [1:0] {C_NEXT, C_INT, C_WARM} cause_t;

  state_t            st;
  cause_t            cause;
  logic [CW-1:0]     cnt;
  logic [PORT_W-1:0] port_q;
  logic [IRQ_N-1:0]  snap;

  logic [PORT_W-1:0] port_fall;
  logic [IRQ_N-1:0]  fresh;
  logic              halt_go, wake_any, take_int;
  cause_t            cause_nx;

  assign port_fall = port_q & ~port_in & port_wake_en;
  assign fresh     = irq_flags & ~snap;
  assign halt_go   = (st == S_RUN) && halt_cmd && !wdt_ovf;
  assign wake_any  = (st == S_HALT) && (wdt_ovf || (|port_fall) || (|fresh));
  assign take_int  = (|(fresh & irq_en)) && !stack_full;
  assign cause_nx  = wdt_ovf ? C_WARM : (take_int ? C_INT : C_NEXT);

  assign cpu_hold    = (st == S_HALT) || (st == S_WAKE);
  assign wdt_clear   = halt_go;
  assign resume_next = (st == S_EXIT) && (cause == C_NEXT);
  assign int_entry   = (st == S_EXIT) && (cause == C_INT);
  assign warm_rst    = (st == S_EXIT) && (cause == C_WARM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_RUN;
      cause  <= C_NEXT;
      cnt    <= '0;
      port_q <= '0;
      snap   <= '0;
    end else begin
      port_q <= port_in;
      unique case (st)
        S_RUN: begin
          if (wdt_ovf) begin
            st    <= S_EXIT;
            cause <= C_WARM;
          end else if (halt_cmd) begin
            st   <= S_HALT;
            snap <= irq_flags;
          end
        end
        S_HALT: begin
          if (wake_any) begin
            st    <= S_WAKE;
            cnt   <= '0;
            cause <= cause_nx;
          end
        end
        S_WAKE: begin
          if (wdt_ovf) cause <= C_WARM;
          if (cnt == LAST) st <= S_EXIT;
          else cnt <= cnt + 1'b1;
        end
        default: st <= S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_flag <= 1'b0;
      to_flag <= 1'b0;
    end else begin
      if (halt_go)         pd_flag <= 1'b1;
      else if (clrwdt_cmd) pd_flag <= 1'b0;
      if (wdt_ovf)         to_flag <= 1'b1;
      else if (halt_go)    to_flag <= 1'b0;
    end
  end

endmodule

module halt_wake_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic halt_cmd,
  input logic clrwdt_cmd,
  input logic wdt_ovf,
  input logic cpu_hold,
  input logic wdt_clear,
  input logic pd_flag,
  input logic to_flag,
  input logic resume_next,
  input logic int_entry,
  input logic warm_rst
);

  // R2
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_hold && !resume_next && !int_entry && !warm_rst && halt_cmd && !wdt_ovf)
      |=> (cpu_hold && pd_flag && !to_flag));

  // R2
  wdt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clear |=> cpu_hold);

  // R3
  pd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clrwdt_cmd && !halt_cmd) |=> !pd_flag);

  // R4
  to_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_ovf |=> to_flag);

  // R4
  warm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |-> to_flag);

  // R9
  exit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resume_next, int_entry, warm_rst}));

  // R9
  exit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_next || int_entry || warm_rst) |=> !(resume_next || int_entry || warm_rst));

  // R8
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_hold) |-> (resume_next || int_entry || warm_rst));

endmodule

bind halt_wake_ctrl halt_wake_ctrl_chk i_chk (.*);

// File: tb/test_halt_wake_ctrl.sv
module test_halt_wake_ctrl;
  localparam int DLY = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt_cmd = 1'b0, clrwdt_cmd = 1'b0, wdt_ovf = 1'b0, stack_full = 1'b0;
  logic [7:0] port_in = 8'hFF, port_wake_en = 8'h00;
  logic [3:0] irq_flags = 4'h0, irq_en = 4'h0;
  logic       cpu_hold, wdt_clear, pd_flag, to_flag, resume_next, int_entry, warm_rst;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  halt_wake_ctrl i_halt_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .halt_cmd(halt_cmd), .clrwdt_cmd(clrwdt_cmd),
    .wdt_ovf(wdt_ovf), .port_in(port_in), .port_wake_en(port_wake_en),
    .irq_flags(irq_flags), .irq_en(irq_en), .stack_full(stack_full),
    .cpu_hold(cpu_hold), .wdt_clear(wdt_clear), .pd_flag(pd_flag), .to_flag(to_flag),
    .resume_next(resume_next), .int_entry(int_entry), .warm_rst(warm_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pulses();
    return {29'd0, warm_rst, int_entry, resume_next};
  endfunction

  task automatic enter_halt();
    @(negedge clk);
    halt_cmd = 1'b1;
    #1;
    chk("R2 wdt_clear", int'(wdt_clear), 1);
    @(negedge clk);
    halt_cmd = 1'b0;
    chk("R2 cpu_hold", int'(cpu_hold), 1);
    chk("R2 pd_flag", int'(pd_flag), 1);
    chk("R2 to_flag", int'(to_flag), 0);
  endtask

  task automatic wait_exit(output int n, output int p);
    n = 0;
    p = 0;
    while (n < 3000) begin
      @(negedge clk);
      n++;
      if (pulses() != 0) begin
        p = pulses();
        break;
      end
      if (!cpu_hold) break;
    end
  endtask

  task automatic after_exit(input string req);
    @(negedge clk);
    chk({req, " pulse width"}, pulses(), 0);
    chk({req, " released"}, int'(cpu_hold), 0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 pd", int'(pd_flag), 0);
    chk("R1 to", int'(to_flag), 0);
    chk("R1 hold", int'(cpu_hold), 0);
    chk("R1 pulses", pulses(), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {pd_flag, to_flag, cpu_hold} , 0);
  endtask

  task automatic t_port();
    int n, p;
    port_wake_en = 8'h04;
    enter_halt();
    port_in = 8'hFE;
    repeat (4) @(negedge clk);
    chk("R5 masked bit ignored", int'(cpu_hold), 1);
    port_in = 8'hFF;
    repeat (4) @(negedge clk);
    chk("R5 rising edge ignored", int'(cpu_hold), 1);
    port_in = 8'hFB;
    wait_exit(n, p);
    chk("R8 delay port", n, DLY + 1);
    chk("R5 port resumes", p, 1);
    after_exit("R9");
    port_in = 8'hFF;
  endtask

  task automatic t_irq_pending();
    int n, p;
    irq_en = 4'hF;
    irq_flags = 4'h2;
    enter_halt();
    repeat (6) @(negedge clk);
    chk("R6 stale flag ignored", int'(cpu_hold), 1);
    irq_flags = 4'h3;
    wait_exit(n, p);
    chk("R8 delay irq", n, DLY + 1);
    chk("R7 int entry", p, 2);
    after_exit("R9");
    irq_flags = 4'h0;
  endtask

  task automatic t_irq_resume(input logic en, input logic full, input string req);
    int n, p;
    irq_en = {3'b000, en};
    stack_full = full;
    enter_halt();
    @(negedge clk);
    irq_flags = 4'h1;
    wait_exit(n, p);
    chk({req, " resume"}, p, 1);
    after_exit("R9");
    irq_flags = 4'h0;
    stack_full = 1'b0;
  endtask

  task automatic t_wdt_halt();
    int n, p;
    port_wake_en = 8'h01;
    enter_halt();
    @(negedge clk);
    wdt_ovf = 1'b1;
    port_in = 8'hFE;
    @(negedge clk);
    wdt_ovf = 1'b0;
    chk("R4 to set", int'(to_flag), 1);
    chk("R4 pd kept", int'(pd_flag), 1);
    wait_exit(n, p);
    chk("R8 delay wdt", n, DLY);
    chk("R4 warm wins", p, 4);
    after_exit("R9");
    port_in = 8'hFF;
  endtask

  task automatic t_clrwdt();
    @(negedge clk);
    clrwdt_cmd = 1'b1;
    @(negedge clk);
    clrwdt_cmd = 1'b0;
    chk("R3 pd cleared", int'(pd_flag), 0);
    chk("R3 to kept", int'(to_flag), 1);
  endtask

  task automatic t_wdt_run();
    @(negedge clk);
    wdt_ovf = 1'b1;
    @(negedge clk);
    wdt_ovf = 1'b0;
    chk("R4 run warm", pulses(), 4);
    chk("R4 run to", int'(to_flag), 1);
    after_exit("R9");
  endtask

  task automatic t_ext_reset();
    enter_halt();
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 pd", int'(pd_flag), 0);
    chk("R10 to", int'(to_flag), 0);
    chk("R10 hold", int'(cpu_hold), 0);
    chk("R10 pulses", pulses(), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 stays run", int'(cpu_hold), 0);
  endtask

  initial begin
    t_reset();
    t_port();
    t_irq_pending();
    t_irq_resume(1'b0, 1'b0, "R7 disabled");
    t_irq_resume(1'b1, 1'b1, "R7 stack full");
    t_wdt_halt();
    t_clrwdt();
    t_wdt_run();
    t_ext_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule